// File: doc/BRIEF.md
# Memory Bus Line Integrity Tester

This block is a self-test sequencer for an external DRAM-style memory. It aims at the wiring around the array rather than at every cell. It looks for stuck data lines, shorted or open data lines, broken column paths and broken row decoders, and it does this in a few hundred cycles instead of a full array sweep.

After a `start` pulse the sequencer runs three phases in a fixed order:

1. **Data-line phase.** Each data line is driven on its own at a single fixed location. A one-hot word is written and read back, then its full-width inverse is written and read back.
2. **Column phase.** Every column of row 0 is written with an address-derived pattern, and then every column is read back.
3. **Row phase.** One word in every row (column 0) is written, and then every row is read back.

Because all writes of a phase land before any read of that phase, an address line that is open or aliased shows up as a data mismatch.

On the first mismatch the sequencer stops issuing requests and raises `done` with `fail`. `fail_phase` and `fail_index` then tell which phase failed and which line, column or row was being checked. `DW` must be even, and `DW/2` must be at least as large as both `RW` and `CW`.

Top module: `bus_line_tester`

## Requirements
- R1: While reset is held and afterwards until `start`, `mem_req`, `done` and `fail` are low.
- R2: The data-line phase steps through lines i = 0 upward to DW-1. For each line it writes the word with only bit i set to row 0, column 0, then reads that location. It then writes the bitwise inverse of that word to the same location and reads it.
- R3: The column phase writes every column of row 0 in ascending order. Only after all columns are written does it read them back in the same ascending order.
- R4: The row phase writes column 0 of every row in ascending row order. Only after all rows are written does it read them back in the same order.
- R5: In the column and row phases, the data for index k is built as follows: bits [DW/2-1:0] hold k zero-extended, and bits [DW-1:DW/2] hold the bitwise complement of that value.
- R6: The phases run data, then column, then row. On a fault-free memory, `done` rises 6·DW + 3·2^CW + 3·2^RW cycles after the edge that samples `start`, with `fail` low and every prescribed request issued.
- R7: Read data is taken on the cycle after the read request and is compared across the full width. A read is never followed directly by another request. On the first mismatch no further request is made, and `done` and `fail` rise on the next cycle.
- R8: `fail_phase` is 0 for the data-line phase, 1 for the column phase and 2 for the row phase. `fail_index` is the line under test, the column, or the row, respectively.
- R9: `done` and the result outputs hold until the next `start`. A `start` while the test is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test when idle or finished |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_row | output | RW | Row address |
| mem_col | output | CW | Column address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read request |
| done | output | 1 | Test finished |
| fail | output | 1 | A mismatch was found |
| fail_phase | output | 2 | Phase of the failure |
| fail_index | output | max(clog2(DW),RW,CW) | Line, column or row of the failure |

## Verification
Every memory request is due on a fixed cycle: writes and reads follow one another directly, and each read is followed by one comparison cycle. The bench therefore compares each request, at the falling edge, against the next entry of a queue built from R2 to R5. It counts edges from the edge that samples `start` to the cycle in which `done` appears. That count is compared with the total from R6 on a healthy memory, and with 1 + 6·i + 3 for a fault first seen at line i's one-hot read. Injected faults in the bench memory model (stuck lines, a line short, and open column and row address bits) exercise each phase's failure report.

// File: rtl/bus_line_tester.sv
module bus_line_tester #(
  parameter int DW = 16,
  parameter int RW = 4,
  parameter int CW = 4,
  localparam int IW = ($clog2(DW) > RW) ? (($clog2(DW) > CW) ? $clog2(DW) : CW)
                                        : ((RW > CW) ? RW : CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          mem_req,
  output logic          mem_we,
  output logic [RW-1:0] mem_row,
  output logic [CW-1:0] mem_col,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          fail,
  output logic [1:0]    fail_phase,
  output logic [IW-1:0] fail_index
);
  localparam int HW = DW / 2;
  localparam logic [1:0] PH_DATA = 2'd0, PH_COL = 2'd1, PH_ROW = 2'd2;

  typedef enum logic [2:0] {IDLE, DWR, DRD, DCHK, AWR, ARD, ACHK, FIN} st_t;

  st_t st;
  logic [1:0]    phase;
  logic [IW-1:0] cnt;
  logic          inv;
  logic          fail_r;

  logic [DW-1:0] one_hot, line_pat, addr_pat;
  logic [HW-1:0] idx_h;
  logic          last_addr, last_line, mismatch;

  assign one_hot   = DW'(1) << cnt;
  assign line_pat  = inv ? ~one_hot : one_hot;
  assign idx_h     = HW'(cnt);
  assign addr_pat  = DW'({~idx_h, idx_h});
  assign last_line = cnt == IW'(DW - 1);
  assign last_addr = (phase == PH_COL) ? (cnt == IW'((1 << CW) - 1))
                                       : (cnt == IW'((1 << RW) - 1));

  assign mem_req   = st == DWR || st == DRD || st == AWR || st == ARD;
  assign mem_we    = st == DWR || st == AWR;
  assign mem_row   = (phase == PH_ROW) ? RW'(cnt) : '0;
  assign mem_col   = (phase == PH_COL) ? CW'(cnt) : '0;
  assign mem_wdata = (phase == PH_DATA) ? line_pat : addr_pat;
  assign mismatch  = mem_rdata != mem_wdata;

  assign done       = st == FIN;
  assign fail       = fail_r;
  assign fail_phase = phase;
  assign fail_index = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      phase  <= PH_DATA;
      cnt    <= '0;
      inv    <= 1'b0;
      fail_r <= 1'b0;
    end else begin
      case (st)
        IDLE, FIN: if (start) begin
          st     <= DWR;
          phase  <= PH_DATA;
          cnt    <= '0;
          inv    <= 1'b0;
          fail_r <= 1'b0;
        end
        DWR: st <= DRD;
        DRD: st <= DCHK;
        DCHK: begin
          if (mismatch) begin
            fail_r <= 1'b1;
            st     <= FIN;
          end else if (!inv) begin
            inv <= 1'b1;
            st  <= DWR;
          end else begin
            inv <= 1'b0;
            if (last_line) begin
              phase <= PH_COL;
              cnt   <= '0;
              st    <= AWR;
            end else begin
              cnt <= cnt + 1'b1;
              st  <= DWR;
            end
          end
        end
        AWR: begin
          if (last_addr) begin
            cnt <= '0;
            st  <= ARD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ARD: st <= ACHK;
        ACHK: begin
          if (mismatch) begin
            fail_r <= 1'b1;
            st     <= FIN;
          end else if (!last_addr) begin
            cnt <= cnt + 1'b1;
            st  <= ARD;
          end else if (phase == PH_COL) begin
            phase <= PH_ROW;
            cnt   <= '0;
            st    <= AWR;
          end else begin
            st <= FIN;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_line_tester_chk.sv
module bus_line_tester_chk #(
  parameter int DW = 16,
  parameter int RW = 4,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_req,
  input logic          mem_we,
  input logic [RW-1:0] mem_row,
  input logic [CW-1:0] mem_col,
  input logic [DW-1:0] mem_wdata,
  input logic          done,
  input logic          fail,
  input logic [1:0]    fail_phase,
  input logic [1:0]    phase
);
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_req); // R7
  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_we) |=> !mem_req); // R7
  AST_FAIL_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n) fail |-> done); // R7
  AST_COL_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && phase == 2'd1) |-> mem_row == '0); // R3
  AST_ROW_COL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && phase == 2'd2) |-> mem_col == '0); // R4
  AST_LINE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && phase == 2'd0) |-> ($countones(mem_wdata) == 1 || $countones(mem_wdata) == DW - 1)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail) && $stable(fail_phase))); // R9
endmodule

bind bus_line_tester bus_line_tester_chk #(.DW(DW), .RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_we(mem_we),
  .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata), .done(done),
  .fail(fail), .fail_phase(fail_phase), .phase(phase)
);

// File: tb/bus_line_tester_bench.sv
module bus_line_tester_bench;
  localparam int DW = 16, RW = 4, CW = 4, IW = 4;
  localparam int NR = 1 << RW, NC = 1 << CW, HW = DW / 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, start = 0;
  logic mem_req, mem_we, done, fail;
  logic [RW-1:0] mem_row;
  logic [CW-1:0] mem_col;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [1:0] fail_phase;
  logic [IW-1:0] fail_index;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_line_tester #(.DW(DW), .RW(RW), .CW(CW)) u_bus_line_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_we(mem_we),
    .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .fail_phase(fail_phase), .fail_index(fail_index));

  // memory model with fault injection
  logic [DW-1:0] mem [NR*NC];
  logic [DW-1:0] st0_mask = '0, st1_mask = '0;
  logic [RW-1:0] row_open = '0;
  logic [CW-1:0] col_open = '0;
  int short_a = -1;

  function automatic int loc(logic [RW-1:0] r, logic [CW-1:0] c);
    return int'({r & ~row_open, c & ~col_open});
  endfunction

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[loc(mem_row, mem_col)] <= mem_wdata;
    if (mem_req && !mem_we) begin
      logic [DW-1:0] v;
      v = mem[loc(mem_row, mem_col)];
      if (short_a >= 0 && (v[short_a] | v[short_a+1])) begin
        v[short_a] = 1'b1;
        v[short_a+1] = 1'b1;
      end
      mem_rdata <= (v | st1_mask) & ~st0_mask;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct packed {
    logic we;
    logic [RW-1:0] row;
    logic [CW-1:0] col;
    logic [DW-1:0] d;
  } req_t;
  req_t q[$];

  function automatic logic [DW-1:0] apat(int k);
    logic [HW-1:0] h;
    h = HW'(k);
    return {~h, h};
  endfunction

  task automatic push_expected();
    q.delete();
    for (int i = 0; i < DW; i++) begin
      logic [DW-1:0] p;
      p = DW'(1) << i;
      q.push_back({1'b1, RW'(0), CW'(0), p});   // R2
      q.push_back({1'b0, RW'(0), CW'(0), p});
      q.push_back({1'b1, RW'(0), CW'(0), ~p});
      q.push_back({1'b0, RW'(0), CW'(0), ~p});
    end
    for (int c = 0; c < NC; c++) q.push_back({1'b1, RW'(0), CW'(c), apat(c)}); // R3 R5
    for (int c = 0; c < NC; c++) q.push_back({1'b0, RW'(0), CW'(c), apat(c)});
    for (int r = 0; r < NR; r++) q.push_back({1'b1, RW'(r), CW'(0), apat(r)}); // R4 R5
    for (int r = 0; r < NR; r++) q.push_back({1'b0, RW'(r), CW'(0), apat(r)});
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (q.size() == 0) begin
        chk(0, "R7", "request after sequence end", 32'(mem_row), 0);
      end else begin
        req_t e;
        e = q.pop_front();
        chk(mem_we == e.we && mem_row == e.row && mem_col == e.col &&
            (!e.we || mem_wdata == e.d), "R2/R3/R4", "request order",
            {mem_we, 3'b0, 4'(mem_row), 4'(mem_col), mem_wdata},
            {e.we, 3'b0, 4'(e.row), 4'(e.col), e.d});
      end
    end
  end

  task automatic run(input string name, input bit exp_fail, input int exp_ph,
                     input int exp_idx, input int exp_cyc, input bit poke_start);
    int n;
    push_expected();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    n = 1;
    while (!done && n < 5000) begin
      if (poke_start && n == 50) start = 1;   // R9 start ignored while running
      if (poke_start && n == 51) start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    chk(done, "R6", {name, " done"}, 32'(done), 1);
    chk(fail == exp_fail, exp_fail ? "R7" : "R6", {name, " fail"}, 32'(fail), 32'(exp_fail));
    chk(n == exp_cyc, "R6", {name, " cycles to done"}, n, exp_cyc);
    if (exp_fail) begin
      chk(fail_phase == 2'(exp_ph), "R8", {name, " phase"}, 32'(fail_phase), exp_ph);
      chk(fail_index == IW'(exp_idx), "R8", {name, " index"}, 32'(fail_index), exp_idx);
    end else begin
      chk(q.size() == 0, "R6", {name, " all requests issued"}, q.size(), 0);
    end
    repeat (3) begin
      @(negedge clk);
      chk(done && !mem_req && fail == exp_fail, "R9", {name, " hold"}, {done, mem_req, fail}, {1'b1, 1'b0, exp_fail});
    end
    q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req && !done && !fail, "R1", "in reset", {mem_req, done, fail}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !done && !fail, "R1", "idle after reset", {mem_req, done, fail}, 0);

    run("healthy", 0, 0, 0, 1 + 6*DW + 3*NC + 3*NR, 1);
    st0_mask = DW'(1) << 11;
    run("stuck0 bit11", 1, 0, 0, 1 + 6, 0);        // R2 inverse catches it
    st0_mask = '0; short_a = 6;
    run("short 6/7", 1, 0, 6, 1 + 6*6 + 3, 0);     // R7 full-width compare
    short_a = -1; st1_mask = DW'(1);
    run("stuck1 bit0", 1, 0, 0, 1 + 6, 0);
    st1_mask = '0; col_open = CW'(4);
    run("column open", 1, 1, 0, 1 + 6*DW + NC + 2, 0);        // R3
    col_open = '0; row_open = RW'(8);
    run("row open", 1, 2, 0, 1 + 6*DW + 3*NC + NR + 2, 0);    // R4
    row_open = '0;
    run("healthy again", 0, 0, 0, 1 + 6*DW + 3*NC + 3*NR, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule